// File: doc/BRIEF.md
# Directed-Mode Mantissa Rounding Unit

This block is the combinational rounding step that sits at the end of a floating-point datapath. It takes an unrounded magnitude with two extra low-order bits, a separate sticky bit, the sign of the value and a 2-bit rounding-mode code. It returns the magnitude with the two extra bits removed and any increment applied. It also reports whether an increment happened and whether any precision was lost.

An increment on an all-ones magnitude carries into the next bit up. That carry is returned on its own output and is not normalised, so the caller adjusts the exponent. The unit also tells the caller, for the current sign and mode, whether an overflowing result must become infinity or the largest finite magnitude.

Mode codes: 00 = nearest with ties to even, 01 = toward zero, 10 = toward plus infinity, 11 = toward minus infinity. Bit 1 of the input magnitude is the guard bit and bit 0 is the round bit. `sign_i` = 1 means negative.

Top module: `rnd_unit`

## Requirements
- R1: With no increment, `{carry_o, mant_o}` equals `mant_i` shifted right by two bits, which drops the guard bit (bit 1) and the round bit (bit 0).
- R2: When guard, round and sticky are all 0, `round_up_o` and `inexact_o` are both 0 in every mode.
- R3: `inexact_o` is 1 exactly when at least one of guard, round or sticky is 1, in every mode.
- R4: In mode 00 there is no increment when guard is 0. When guard is 1, the value is incremented if round is 1, sticky is 1, or bit 0 of the shifted magnitude is 1, so an exact tie goes to the even result.
- R5: Mode 01 never increments.
- R6: Mode 10 increments an inexact positive value (`sign_i` = 0) and never a negative one. Mode 11 increments an inexact negative value and never a positive one.
- R7: `round_up_o` is 1 exactly when the increment was applied. `{carry_o, mant_o}` equals the shifted magnitude plus `round_up_o`, with the carry running across the full width. An all-ones shifted magnitude that is incremented gives `carry_o` = 1 and `mant_o` = 0.
- R8: `ovf_to_inf_o` is 1 in mode 00 and 0 in mode 01. It equals `!sign_i` in mode 10 and `sign_i` in mode 11.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sign_i | input | 1 | Sign of the value, 1 = negative |
| mant_i | input | MANT_IN_W | Unrounded magnitude; bit 1 is guard, bit 0 is round |
| sticky_i | input | 1 | OR of all bits below the round bit |
| mode_i | input | 2 | Rounding-mode code |
| mant_o | output | MANT_IN_W-2 | Rounded magnitude |
| carry_o | output | 1 | Carry out of the increment, not normalised |
| round_up_o | output | 1 | 1 when the increment was applied |
| inexact_o | output | 1 | 1 when any discarded bit was nonzero |
| ovf_to_inf_o | output | 1 | 1 when an overflow of this sign in this mode goes to infinity |

## Verification
The assertions check, for every input combination the bench applies, the relations that hold on their own. An exact input yields no flags. Mode 01 and the wrong-sign directed cases never increment. Mode 00 never rounds up with guard clear. The outputs always equal the shifted input plus the round-up flag. The overflow target is fixed in the two sign-independent modes. What the assertions cannot establish is that the increment decision is right in every other case. That covers tie-to-even against odd, and directed rounding of the correct sign. The bench shows these by sweeping every magnitude, sign, sticky and mode of a narrow configuration and comparing against arithmetic computed on its own side.

// File: rtl/rnd_pkg.sv
package rnd_pkg;
  typedef enum logic [1:0] {
    RM_NEAREST = 2'b00,
    RM_ZERO    = 2'b01,
    RM_UP      = 2'b10,
    RM_DOWN    = 2'b11
  } rmode_e;
endpackage

// File: rtl/rnd_decide.sv
// Increment and inexact decision from the discarded bits, the sign and the mode.
module rnd_decide
  import rnd_pkg::*;
(
  input  logic   sign_i,
  input  logic   guard_i,
  input  logic   round_i,
  input  logic   sticky_i,
  input  logic   lsb_i,
  input  rmode_e mode_i,
  output logic   inc_o,
  output logic   inexact_o
);
  logic lost;

  always_comb begin
    lost      = guard_i | round_i | sticky_i;
    inexact_o = lost;
    inc_o     = 1'b0;
    if (lost) begin
      case (mode_i)
        RM_ZERO: inc_o = 1'b0;
        RM_UP:   inc_o = ~sign_i;
        RM_DOWN: inc_o = sign_i;
        default: inc_o = guard_i & (round_i | sticky_i | lsb_i);
      endcase
    end
  end
endmodule

// File: rtl/rnd_ovf_target.sv
// Saturation target for an overflowing result of the given sign.
module rnd_ovf_target
  import rnd_pkg::*;
(
  input  logic   sign_i,
  input  rmode_e mode_i,
  output logic   to_inf_o
);
  always_comb begin
    case (mode_i)
      RM_ZERO: to_inf_o = 1'b0;
      RM_UP:   to_inf_o = ~sign_i;
      RM_DOWN: to_inf_o = sign_i;
      default: to_inf_o = 1'b1;
    endcase
  end
endmodule

// File: rtl/rnd_incr.sv
// Ripple incrementer with the carry out kept separate.
module rnd_incr #(
  parameter int W = 24
) (
  input  logic [W-1:0] base_i,
  input  logic         inc_i,
  output logic [W-1:0] sum_o,
  output logic         carry_o
);
  logic [W:0] chain;

  assign chain[0] = inc_i;

  for (genvar k = 0; k < W; k++) begin : g_bit
    assign sum_o[k]    = base_i[k] ^ chain[k];
    assign chain[k+1]  = base_i[k] & chain[k];
  end

  assign carry_o = chain[W];
endmodule

// File: rtl/rnd_unit.sv
module rnd_unit
  import rnd_pkg::*;
#(
  parameter int MANT_IN_W = 26,
  localparam int OUT_W    = MANT_IN_W - 2
) (
  input  logic                 sign_i,
  input  logic [MANT_IN_W-1:0] mant_i,
  input  logic                 sticky_i,
  input  logic [1:0]           mode_i,
  output logic [OUT_W-1:0]     mant_o,
  output logic                 carry_o,
  output logic                 round_up_o,
  output logic                 inexact_o,
  output logic                 ovf_to_inf_o
);
  rmode_e           mode;
  logic [OUT_W-1:0] shifted;
  logic             inc;

  assign mode    = rmode_e'(mode_i);
  assign shifted = mant_i[MANT_IN_W-1:2];

  rnd_decide i_decide (
    .sign_i    (sign_i),
    .guard_i   (mant_i[1]),
    .round_i   (mant_i[0]),
    .sticky_i  (sticky_i),
    .lsb_i     (shifted[0]),
    .mode_i    (mode),
    .inc_o     (inc),
    .inexact_o (inexact_o)
  );

  rnd_incr #(.W(OUT_W)) i_incr (
    .base_i  (shifted),
    .inc_i   (inc),
    .sum_o   (mant_o),
    .carry_o (carry_o)
  );

  rnd_ovf_target i_ovf (
    .sign_i   (sign_i),
    .mode_i   (mode),
    .to_inf_o (ovf_to_inf_o)
  );

  assign round_up_o = inc;
endmodule

// File: rtl/rnd_unit_chk.sv
module rnd_unit_chk #(
  parameter int MANT_IN_W = 26,
  localparam int OUT_W    = MANT_IN_W - 2
) (
  input logic                 sign_i,
  input logic [MANT_IN_W-1:0] mant_i,
  input logic                 sticky_i,
  input logic [1:0]           mode_i,
  input logic [OUT_W-1:0]     mant_o,
  input logic                 carry_o,
  input logic                 round_up_o,
  input logic                 inexact_o,
  input logic                 ovf_to_inf_o
);
  logic [OUT_W:0] expect_sum;

  always_comb begin
    expect_sum = {1'b0, mant_i[MANT_IN_W-1:2]} + {{OUT_W{1'b0}}, round_up_o};
    if (!(mant_i[1] | mant_i[0] | sticky_i))
      a_r2_exact: assert (!round_up_o && !inexact_o)
        else $error("R2 flags on exact input");
    if (mode_i == 2'b01)
      a_r5_zero_no_inc: assert (!round_up_o)
        else $error("R5 increment in toward-zero");
    if ((mode_i == 2'b10 && sign_i) || (mode_i == 2'b11 && !sign_i))
      a_r6_wrong_sign: assert (!round_up_o)
        else $error("R6 increment of wrong sign");
    if (mode_i == 2'b00 && !mant_i[1])
      a_r4_guard_clear: assert (!round_up_o)
        else $error("R4 increment with guard clear");
    a_r7_sum: assert ({carry_o, mant_o} == expect_sum)
      else $error("R7 sum mismatch");
    if (mode_i == 2'b00)
      a_r8_nearest_inf: assert (ovf_to_inf_o)
        else $error("R8 nearest not to infinity");
    if (mode_i == 2'b01)
      a_r8_zero_max: assert (!ovf_to_inf_o)
        else $error("R8 toward-zero to infinity");
  end
endmodule

bind rnd_unit rnd_unit_chk #(.MANT_IN_W(MANT_IN_W)) i_chk (
  .sign_i       (sign_i),
  .mant_i       (mant_i),
  .sticky_i     (sticky_i),
  .mode_i       (mode_i),
  .mant_o       (mant_o),
  .carry_o      (carry_o),
  .round_up_o   (round_up_o),
  .inexact_o    (inexact_o),
  .ovf_to_inf_o (ovf_to_inf_o)
);

// File: tb/test_rnd_unit.sv
`timescale 1ns/1ps
module test_rnd_unit;
  localparam int IW = 6;
  localparam int OW = IW - 2;

  logic          clk = 1'b0;
  logic          sign;
  logic [IW-1:0] mant;
  logic          sticky;
  logic [1:0]    mode;
  logic [OW-1:0] mant_o;
  logic          carry_o, round_up_o, inexact_o, ovf_to_inf_o;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  rnd_unit #(.MANT_IN_W(IW)) i_rnd_unit (
    .sign_i       (sign),
    .mant_i       (mant),
    .sticky_i     (sticky),
    .mode_i       (mode),
    .mant_o       (mant_o),
    .carry_o      (carry_o),
    .round_up_o   (round_up_o),
    .inexact_o    (inexact_o),
    .ovf_to_inf_o (ovf_to_inf_o)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d (mode=%0d sign=%0d mant=%0d sticky=%0d)",
               req, act, exp, mode, sign, mant, sticky);
    end
  endtask

  task automatic apply(input int md, input int sg, input int m, input int st);
    int g, r, base, lost, inc, tinf, sum;
    @(negedge clk);
    mode = md[1:0]; sign = sg[0]; mant = m[IW-1:0]; sticky = st[0];
    g    = (m >> 1) & 1;
    r    = m & 1;
    base = m >> 2;
    lost = (g | r | st) != 0 ? 1 : 0;
    case (md)
      0:       inc = (g == 1 && (r == 1 || st == 1 || (base & 1) == 1)) ? 1 : 0;
      1:       inc = 0;
      2:       inc = (lost == 1 && sg == 0) ? 1 : 0;
      default: inc = (lost == 1 && sg == 1) ? 1 : 0;
    endcase
    case (md)
      0:       tinf = 1;
      1:       tinf = 0;
      2:       tinf = (sg == 0) ? 1 : 0;
      default: tinf = sg;
    endcase
    sum = base + inc;
    @(posedge clk);
    check("R3 inexact", int'(inexact_o), lost);
    if (lost == 0) check("R2 exact no round-up", int'(round_up_o), 0);
    else if (md == 0) check("R4 nearest round-up", int'(round_up_o), inc);
    else if (md == 1) check("R5 toward-zero round-up", int'(round_up_o), inc);
    else check("R6 directed round-up", int'(round_up_o), inc);
    if (inc == 0) check("R1 shifted magnitude", int'({carry_o, mant_o}), base);
    else check("R7 incremented magnitude", int'({carry_o, mant_o}), sum);
    check("R8 overflow target", int'(ovf_to_inf_o), tinf);
  endtask

  initial begin
    // R4 tie cases: even stays, odd rounds up
    apply(0, 0, 6'b001010, 0);
    check("R4 tie even stays", int'(round_up_o), 0);
    apply(0, 0, 6'b000110, 0);
    check("R4 tie odd rounds up", int'(round_up_o), 1);
    // R7 all-ones carry out
    apply(2, 0, 6'b111101, 0);
    check("R7 carry out set", int'(carry_o), 1);
    check("R7 mantissa wraps to zero", int'(mant_o), 0);
    // Exhaustive sweep
    for (int md = 0; md < 4; md++)
      for (int sg = 0; sg < 2; sg++)
        for (int st = 0; st < 2; st++)
          for (int m = 0; m < (1 << IW); m++)
            apply(md, sg, m, st);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule